// File: doc/BRIEF.md
# Double-Buffered Prescaled PWM Generator

This block drives one pulse-width-modulated output from a small register file reached through a plain read/write port. Software chooses a prescaler value, a period count and a high-time count. The period lasts (div+1)·(period+1) clock cycles. The output is high for the first (div+1)·high cycles of each period. One enable bit starts and stops the waveform.

Writes to the two control registers land in shadow copies, and reads always return those copies. By default the counters use a separate working copy. That copy picks up the shadow values only after software releases a commit bit by writing 1 and then 0. The new values are applied at the next period boundary, so no period is ever cut short. When the mode field holds 0b11, control writes reach the working copy directly and affect the next cycle.

Register map: 0x00 enable (bit 0), 0x04 commit (bit 0), 0x08 prescale (div at bits 25:16), 0x0C timing (period at bits 11:0, high at bits 28:16), 0x10 mode (bits 1:0).

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low.
- R2: Each register reads back the last value written, restricted to its fields: 0xFFFFFFFF written to 0x08 reads 0x03FF0000, to 0x0C reads 0x1FFF0FFF, to 0x10 reads 0x3, and to 0x00 reads 0x1.
- R3: While enabled, the output period is (div+1)·(period+1) clock cycles.
- R4: While enabled, the output is high for the first (div+1)·high cycles of each period. The first period starts in the cycle after the enabling write.
- R5: With high = 0, the output stays low.
- R6: With high > period, the output stays high for the whole period.
- R7: While enable bit 0 is 0, the output is low. Clearing the bit drops the output in the next cycle. Setting it again starts a fresh period.
- R8: In double-buffered mode (mode ≠ 0b11), writes to 0x08 and 0x0C do not change the output until a commit.
- R9: Writing 1 and then 0 to bit 0 of 0x04 captures the shadow values. They are applied at the next period boundary, or at once if the block is disabled.
- R10: With mode = 0b11, a write to 0x08 or 0x0C drives the working values directly, and the output follows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
Two events can fall in the same cycle: the application of a pending commit and the end of a period.

The bench provokes this by releasing a commit while the waveform is running. It then checks that every full period before the boundary keeps the old high time and that every period after it shows the new one.

A second overlap is a bypass-mode write to the timing register while the counters are mid-period. That case is judged by the output level in the very next cycle.

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int AW     = 5,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HI_W   = 13,
  parameter int DIV_LSB = 16,
  parameter int HI_LSB  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          pwm_out
);
  localparam logic [AW-1:0] A_EN  = AW'(5'h00);
  localparam logic [AW-1:0] A_CMT = AW'(5'h04);
  localparam logic [AW-1:0] A_C0  = AW'(5'h08);
  localparam logic [AW-1:0] A_C1  = AW'(5'h0C);
  localparam logic [AW-1:0] A_MD  = AW'(5'h10);

  logic             en_q, commit_q, pend;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] sh_div, st_div, wk_div, pre_cnt;
  logic [PER_W-1:0] sh_per, st_per, wk_per, per_cnt;
  logic [HI_W-1:0]  sh_hi, st_hi, wk_hi;

  wire bypass = (mode_q == 2'b11);
  wire w_en  = bus_wr && (bus_addr == A_EN);
  wire w_cmt = bus_wr && (bus_addr == A_CMT);
  wire w_c0  = bus_wr && (bus_addr == A_C0);
  wire w_c1  = bus_wr && (bus_addr == A_C1);
  wire w_md  = bus_wr && (bus_addr == A_MD);

  wire [DIV_W-1:0] wd_div = bus_wdata[DIV_LSB +: DIV_W];
  wire [PER_W-1:0] wd_per = bus_wdata[PER_W-1:0];
  wire [HI_W-1:0]  wd_hi  = bus_wdata[HI_LSB +: HI_W];

  wire release_c = w_cmt && commit_q && !bus_wdata[0];
  wire tick      = (pre_cnt >= wk_div);
  wire wrap      = tick && (per_cnt >= wk_per);
  wire apply     = (release_c || pend) && (wrap || !en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; commit_q <= 1'b0; mode_q <= 2'b00;
      sh_div <= '0; sh_per <= '0; sh_hi <= '0;
    end else begin
      if (w_en)  en_q     <= bus_wdata[0];
      if (w_cmt) commit_q <= bus_wdata[0];
      if (w_md)  mode_q   <= bus_wdata[1:0];
      if (w_c0)  sh_div   <= wd_div;
      if (w_c1)  begin sh_per <= wd_per; sh_hi <= wd_hi; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; st_div <= '0; st_per <= '0; st_hi <= '0;
      wk_div <= '0; wk_per <= '0; wk_hi <= '0;
    end else begin
      if (release_c) begin
        st_div <= sh_div; st_per <= sh_per; st_hi <= sh_hi;
      end
      if (apply) begin
        pend   <= 1'b0;
        wk_div <= release_c ? sh_div : st_div;
        wk_per <= release_c ? sh_per : st_per;
        wk_hi  <= release_c ? sh_hi  : st_hi;
      end else if (release_c) begin
        pend <= 1'b1;
      end
      if (bypass && w_c0) wk_div <= wd_div;
      if (bypass && w_c1) begin wk_per <= wd_per; wk_hi <= wd_hi; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pre_cnt <= '0; per_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= wrap ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_out = en_q && (HI_W'(per_cnt) < wk_hi);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN:  bus_rdata[0] = en_q;
      A_CMT: bus_rdata[0] = commit_q;
      A_C0:  bus_rdata[DIV_LSB +: DIV_W] = sh_div;
      A_C1:  begin bus_rdata[PER_W-1:0] = sh_per; bus_rdata[HI_LSB +: HI_W] = sh_hi; end
      A_MD:  bus_rdata[1:0] = mode_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int AW = 5, parameter int DIV_W = 10,
  parameter int PER_W = 12, parameter int HI_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             bypass,
  input logic [DIV_W-1:0] pre_cnt,
  input logic [DIV_W-1:0] wk_div,
  input logic [PER_W-1:0] per_cnt,
  input logic [PER_W-1:0] wk_per,
  input logic [HI_W-1:0]  wk_hi,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             pwm_out
);
  localparam logic [AW-1:0] C1 = AW'(5'h0C);

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_out); // R7
  AST_HOLD_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !bypass && !((pre_cnt >= wk_div) && (per_cnt >= wk_per)))
      |=> ($stable(wk_per) && $stable(wk_div) && $stable(wk_hi))); // R9
  AST_BYP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && bus_wr && bus_addr == C1)
      |=> (wk_per == $past(bus_wdata[PER_W-1:0]))); // R10
  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C1) |-> (bus_rdata[31:29] == 3'b0 && bus_rdata[15:12] == 4'b0)); // R2
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_q) && wk_hi != '0) |-> pwm_out); // R4
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.AW(AW), .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .bypass(bypass),
  .pre_cnt(pre_cnt), .wk_div(wk_div), .per_cnt(per_cnt), .wk_per(wk_per),
  .wk_hi(wk_hi), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out)
);

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  pwm_dbuf u_pwm_dbuf (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  // vector: div[34:25], per[24:13], hi[12:0]
  localparam int NV = 5;
  localparam logic [34:0] VEC [NV] = '{
    {10'd0, 12'd9, 13'd3}, {10'd2, 12'd4, 13'd1}, {10'd1, 12'd7, 13'd5},
    {10'd3, 12'd2, 13'd2}, {10'd0, 12'd1, 13'd1}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; @(negedge clk);
  endtask

  function automatic logic [31:0] c0(input int dv); return 32'(dv) << 16; endfunction
  function automatic logic [31:0] c1(input int p, input int h);
    return (32'(h) << 16) | 32'(p);
  endfunction

  task automatic cnt_high(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) k++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int dv, input int p, input int h);
    wr(5'h00, 32'h0);
    wr(5'h08, c0(dv));
    wr(5'h0C, c1(p, h));
    wr(5'h04, 32'h1);
    wr(5'h04, 32'h0);
    wr(5'h00, 32'h1);
  endtask

  task automatic measure(output int hl, output int tot);
    int g;
    logic prev;
    hl = 0; tot = 0; g = 0;
    prev = pwm_out; @(negedge clk);
    while (!(pwm_out && !prev) && g < 5000) begin prev = pwm_out; @(negedge clk); g++; end
    while (pwm_out && g < 5000) begin hl++; tot++; @(negedge clk); g++; end
    while (!pwm_out && g < 5000) begin tot++; @(negedge clk); g++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k, hl, tot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm", int'(pwm_out), 0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), d); chk("R1 reg", int'(d), 0);
    end

    // R2 readback masks
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); chk("R2 prescale", int'(d), 32'h03FF_0000);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); chk("R2 timing", int'(d), 32'h1FFF_0FFF);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); chk("R2 mode", int'(d), 3);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk("R2 enable", int'(d), 1);
    wr(5'h00, 32'h0);
    chk("R8 no commit keeps low", int'(pwm_out), 0);

    // R3/R4 vector table
    for (int v = 0; v < NV; v++) begin
      int dv, p, h;
      dv = int'(VEC[v][34:25]); p = int'(VEC[v][24:13]); h = int'(VEC[v][12:0]);
      setup(dv, p, h);
      chk("R4 first cycle high", int'(pwm_out), 1);
      measure(hl, tot);
      chk("R3 period", tot, (dv + 1) * (p + 1));
      chk("R4 high time", hl, (dv + 1) * h);
    end

    // R5 high zero
    setup(1, 5, 0);
    cnt_high(40, k); chk("R5 high zero", k, 0);

    // R6 high > period
    setup(1, 3, 5);
    cnt_high(40, k); chk("R6 always high", k, 40);

    // R7 disable and restart
    setup(0, 9, 3);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'h0);
    chk("R7 drop next cycle", int'(pwm_out), 0);
    cnt_high(20, k); chk("R7 stays low", k, 0);
    repeat (3) @(negedge clk);
    wr(5'h00, 32'h1);
    cnt_high(3, k); chk("R7 restart high", k, 3);
    chk("R7 restart low", int'(pwm_out), 0);

    // R8/R9 double-buffered update while running (period 10, high 3)
    wr(5'h0C, c1(9, 7));
    cnt_high(10, k); chk("R8 shadow ignored", k, 3);
    cnt_high(10, k); chk("R8 shadow ignored again", k, 3);
    wr(5'h04, 32'h1);
    cnt_high(10, k); chk("R8 set without release", k, 3);
    wr(5'h04, 32'h0);
    repeat (10) @(negedge clk);
    cnt_high(10, k); chk("R9 committed high", k, 7);
    measure(hl, tot);
    chk("R9 period", tot, 10);
    chk("R9 high", hl, 7);

    // R10 bypass writes
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h3);
    wr(5'h08, c0(0));
    wr(5'h0C, c1(9, 0));
    wr(5'h00, 32'h1);
    repeat (4) @(negedge clk);
    chk("R10 low before", int'(pwm_out), 0);
    wr(5'h0C, c1(9, 13));
    chk("R10 next cycle high", int'(pwm_out), 1);
    cnt_high(20, k); chk("R10 stays high", k, 20);
    wr(5'h0C, c1(9, 0));
    chk("R10 next cycle low", int'(pwm_out), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule